// File: doc/BRIEF.md
# Word Shift and Rotate Unit with Condition Flags

A purely combinational datapath unit that moves the bits of a 32-bit operand left or right and reports negative, zero and carry flags for the outcome. It covers five operations: logical left shift, logical right shift, arithmetic right shift, rotate right, and a one-position rotate right that passes through the carry flag. Its result and flags become valid in the same cycle as its inputs, so it can sit in an execute stage next to the adder.

The shift distance comes from one of two places. The first is a 5-bit immediate field from the instruction word. The second is an 8-bit count taken from the bottom byte of a register, which may range from 0 to 255, well past the word width. Every distance yields a defined carry-out. A distance of zero leaves the carry exactly as it came in, and distances of the word width or more are handled as the requirements below define. The caller decides whether the flags are written.

Top module: `shrot_unit`

## Requirements
- R1: `op_i` selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right and 4 is rotate through carry. Codes 5 to 7 give `res_o` equal to `opnd_i` and `c_o` equal to `c_i`.
- R2: With `amt_sel_i`=1 the distance is `reg_amt_i` (0 to 255). With `amt_sel_i`=0 it is taken from `imm_i`.
- R3: An immediate of 0 means a distance of 32 for the logical right and arithmetic right codes. It means a distance of 0 for logical left and rotate right.
- R4: For codes 0 to 3 with a distance of 0, `res_o` equals `opnd_i` and `c_o` equals `c_i`.
- R5: A logical left shift by n in 1..31 fills the vacated low bits with zeros, and `c_o` is `opnd_i[32-n]`.
- R6: A logical or arithmetic right shift by n in 1..31 gives `c_o` equal to `opnd_i[n-1]`. The vacated high bits are filled with zeros for the logical shift and with copies of `opnd_i[31]` for the arithmetic shift.
- R7: A logical shift by exactly 32 gives a zero result, with `c_o` equal to `opnd_i[0]` for left and `opnd_i[31]` for right. A logical shift by more than 32 gives zero with `c_o`=0.
- R8: An arithmetic right shift by 32 or more copies `opnd_i[31]` into every bit of the result, and `c_o` is `opnd_i[31]`.
- R9: A rotate right uses the distance modulo 32, and for a nonzero distance `c_o` equals `res_o[31]`. A nonzero multiple of 32 leaves the operand unchanged.
- R10: Rotate through carry ignores the distance. It gives `res_o` = {`c_i`, `opnd_i[31:1]`} and `c_o` = `opnd_i[0]`.
- R11: `n_o` equals `res_o[31]`, and `z_o` is 1 exactly when `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Value to be shifted or rotated |
| op_i | input | 3 | Operation code |
| amt_sel_i | input | 1 | 1: distance from register byte, 0: from immediate |
| imm_i | input | 5 | Immediate distance field |
| reg_amt_i | input | 8 | Bottom byte of the distance register |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted or rotated word |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Outgoing carry flag |

## Verification
Every output of this unit is due in the same cycle as its stimulus, because no register lies on any path. The bench therefore changes the inputs just after a rising clock edge and reads the result, the flags and the carry at the next falling edge. By then the combinational logic has settled, and no edge ordering can affect the reading. Each expected value comes from a reference model that moves the operand one position at a time for the full distance. This catches off-by-one errors at distances 31, 32, 33, 64 and 255, which a model built as a barrel shifter would repeat.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4
  } shrot_op_e;
endpackage

// File: rtl/shrot_amount.sv
module shrot_amount
  import shrot_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = $clog2(W)
) (
  input  logic [2:0]       op_i,
  input  logic             amt_sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AMT_W-1:0] reg_amt_i,
  output logic [AMT_W-1:0] amt_o
);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

  logic right_op;
  assign right_op = (op_i == OP_LSR) || (op_i == OP_ASR);

  always_comb begin
    if (amt_sel_i)                    amt_o = reg_amt_i;
    else if (imm_i == '0 && right_op) amt_o = AMT_FULL;  // imm 0 encodes full word
    else                              amt_o = AMT_W'(imm_i);
  end
endmodule

// File: rtl/shrot_rshift.sv
module shrot_rshift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [2*W:0]  din_i,
  input  logic [SW-1:0] sh_i,
  output logic [2*W:0]  dout_o
);
  logic [2*W:0] stg [SW+1];

  assign stg[0] = din_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stg[k+1] = sh_i[k] ? (stg[k] >> (2**k)) : stg[k];
  end

  assign dout_o = stg[SW];
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [2:0]       op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [W-1:0]     x_i,
  input  logic             c_i,
  output logic [W-1:0]     res_o,
  output logic             c_o
);
  localparam int LW = $clog2(W);
  localparam int SW = LW + 1;
  localparam logic [SW-1:0]    S_FULL   = SW'(W);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic           over, amt_nz;
  logic [LW-1:0]  rot_lo;
  logic [W-1:0]   src, upper, sh_res;
  logic [SW-1:0]  sh;
  logic [2*W:0]   ext, dout;
  logic           sh_c;

  assign over   = amt_i > AMT_FULL;
  assign amt_nz = |amt_i;
  assign rot_lo = amt_i[LW-1:0];

  // left shift reuses the right shifter on the bit-reversed operand
  assign src = (op_i == OP_LSL) ? rev(x_i) : x_i;

  always_comb begin
    case (op_i)
      OP_ROR:  upper = x_i;
      OP_ASR:  upper = {W{x_i[W-1]}};
      default: upper = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_ROR) sh = (rot_lo == '0) ? S_FULL : {1'b0, rot_lo};
    else                sh = over ? S_FULL : amt_i[SW-1:0];
  end

  assign ext = {upper, src, 1'b0};

  shrot_rshift #(.W(W), .SW(SW)) u_rshift (
    .din_i  (ext),
    .sh_i   (sh),
    .dout_o (dout)
  );

  assign sh_res = dout[W:1];
  assign sh_c   = dout[0];

  always_comb begin
    res_o = x_i;
    c_o   = c_i;
    case (op_i)
      OP_LSL: begin
        if (amt_nz) begin
          res_o = over ? '0   : rev(sh_res);
          c_o   = over ? 1'b0 : sh_c;
        end
      end
      OP_LSR: begin
        if (amt_nz) begin
          res_o = over ? '0   : sh_res;
          c_o   = over ? 1'b0 : sh_c;
        end
      end
      OP_ASR, OP_ROR: begin
        if (amt_nz) begin
          res_o = sh_res;
          c_o   = sh_c;
        end
      end
      OP_RRX: begin
        res_o = {c_i, x_i[W-1:1]};
        c_o   = x_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         n_o,
  output logic         z_o
);
  assign n_o = res_i[W-1];
  assign z_o = ~|res_i;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [2:0]       op_i,
  input  logic             amt_sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AMT_W-1:0] reg_amt_i,
  input  logic             c_i,
  output logic [W-1:0]     res_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o
);
  logic [AMT_W-1:0] amt;

  shrot_amount #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amount (
    .op_i      (op_i),
    .amt_sel_i (amt_sel_i),
    .imm_i     (imm_i),
    .reg_amt_i (reg_amt_i),
    .amt_o     (amt)
  );

  shrot_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .op_i  (op_i),
    .amt_i (amt),
    .x_i   (opnd_i),
    .c_i   (c_i),
    .res_o (res_o),
    .c_o   (c_o)
  );

  shrot_flags #(.W(W)) u_flags (
    .res_i (res_o),
    .n_o   (n_o),
    .z_o   (z_o)
  );
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = $clog2(W)
) (
  input logic [W-1:0]     opnd_i,
  input logic [2:0]       op_i,
  input logic             amt_sel_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [AMT_W-1:0] reg_amt_i,
  input logic             c_i,
  input logic [W-1:0]     res_o,
  input logic             n_o,
  input logic             z_o,
  input logic             c_o
);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

  always_comb begin
    AST_BAD_OP_PASS: assert (op_i < 3'd5 || (res_o == opnd_i && c_o == c_i)) else $error("bad op not passed"); // R1
    AST_IMM_FULL: assert (!(!amt_sel_i && imm_i == '0 && op_i == 3'd1) || (res_o == '0 && c_o == opnd_i[W-1])) else $error("imm 0 right shift"); // R3
    AST_ZERO_AMT: assert (!(amt_sel_i && reg_amt_i == '0 && op_i < 3'd4) || (res_o == opnd_i && c_o == c_i)) else $error("zero distance"); // R4
    AST_LOG_OVER: assert (!(amt_sel_i && reg_amt_i > AMT_FULL && op_i < 3'd2) || (res_o == '0 && !c_o)) else $error("logical overshift"); // R7
    AST_ASR_FILL: assert (!(amt_sel_i && reg_amt_i >= AMT_FULL && op_i == 3'd2) || (res_o == {W{opnd_i[W-1]}} && c_o == opnd_i[W-1])) else $error("asr fill"); // R8
    AST_ROR_CARRY: assert (!(amt_sel_i && reg_amt_i != '0 && op_i == 3'd3) || c_o == res_o[W-1]) else $error("ror carry"); // R9
    AST_RRX_FORM: assert (op_i != 3'd4 || (res_o == {c_i, opnd_i[W-1:1]} && c_o == opnd_i[0])) else $error("rrx form"); // R10
    AST_N_FLAG: assert (n_o == res_o[W-1]) else $error("n flag"); // R11
    AST_Z_FLAG: assert (z_o == (res_o == '0)) else $error("z flag"); // R11
  end
endmodule

bind shrot_unit shrot_unit_chk #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_chk (
  .opnd_i    (opnd_i),
  .op_i      (op_i),
  .amt_sel_i (amt_sel_i),
  .imm_i     (imm_i),
  .reg_amt_i (reg_amt_i),
  .c_i       (c_i),
  .res_o     (res_o),
  .n_o       (n_o),
  .z_o       (z_o),
  .c_o       (c_o)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [2:0]  op_i = '0;
  logic        amt_sel_i = 1'b0;
  logic [4:0]  imm_i = '0;
  logic [7:0]  reg_amt_i = '0;
  logic        c_i = 1'b0;
  logic [31:0] res_o;
  logic        n_o, z_o, c_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  shrot_unit u_dut (
    .opnd_i(opnd_i), .op_i(op_i), .amt_sel_i(amt_sel_i), .imm_i(imm_i),
    .reg_amt_i(reg_amt_i), .c_i(c_i), .res_o(res_o), .n_o(n_o), .z_o(z_o), .c_o(c_o)
  );

  // reference: one position per step
  task automatic ref_model(input logic [2:0] op, input logic [31:0] x, input int amt,
                           input logic cin, output logic [31:0] r, output logic c);
    r = x;
    c = cin;
    if (op == 3'd4) begin
      c = x[0];
      r = {cin, x[31:1]};
    end else if (op < 3'd4) begin
      for (int i = 0; i < amt; i++) begin
        case (op)
          3'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
          3'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
          3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] op, input logic sel,
                       input logic [4:0] imm, input logic [7:0] ramt,
                       input logic [31:0] x, input logic cin);
    int amt;
    logic [31:0] er;
    logic ec;
    @(posedge clk);
    op_i = op; amt_sel_i = sel; imm_i = imm; reg_amt_i = ramt; opnd_i = x; c_i = cin;
    if (sel) amt = int'(ramt);
    else if (imm == 5'd0 && (op == 3'd1 || op == 3'd2)) amt = 32;
    else amt = int'(imm);
    ref_model(op, x, amt, cin, er, ec);
    @(negedge clk);
    checks++;
    if (res_o !== er || c_o !== ec || n_o !== er[31] || z_o !== (er == 32'd0)) begin
      errors++;
      $display("FAIL %s op=%0d amt=%0d x=%h: res=%h c=%b n=%b z=%b expected res=%h c=%b n=%b z=%b",
               tag, op, amt, x, res_o, c_o, n_o, z_o, er, ec, er[31], er == 32'd0);
    end
  endtask

  task automatic t_reset_state;
    apply("R11 idle", 3'd0, 1'b0, 5'd0, 8'd0, 32'd0, 1'b0);
  endtask

  task automatic t_bad_codes;
    for (int k = 5; k < 8; k++) begin
      apply("R1 bad code", 3'(k), 1'b1, 5'd3, 8'd7, 32'hA5A5_0F0F, 1'b1);
      apply("R1 bad code", 3'(k), 1'b0, 5'd9, 8'd0, 32'h1234_5678, 1'b0);
    end
  endtask

  task automatic t_amount_source;
    apply("R2 reg src", 3'd1, 1'b1, 5'd1, 8'd12, 32'hF000_00FF, 1'b0);
    apply("R2 imm src", 3'd1, 1'b0, 5'd4, 8'd200, 32'hF000_00FF, 1'b0);
    apply("R2 reg 255", 3'd3, 1'b1, 5'd0, 8'd255, 32'h8000_0001, 1'b0);
  endtask

  task automatic t_imm_zero;
    apply("R3 lsr imm0", 3'd1, 1'b0, 5'd0, 8'd0, 32'h8000_0000, 1'b0);
    apply("R3 asr imm0", 3'd2, 1'b0, 5'd0, 8'd0, 32'h8765_4321, 1'b0);
    apply("R3 lsl imm0", 3'd0, 1'b0, 5'd0, 8'd0, 32'hDEAD_BEEF, 1'b1);
    apply("R3 ror imm0", 3'd3, 1'b0, 5'd0, 8'd0, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_zero_amt;
    for (int k = 0; k < 4; k++) begin
      apply("R4 zero reg", 3'(k), 1'b1, 5'd5, 8'd0, 32'hC001_D00D, 1'b1);
      apply("R4 zero reg", 3'(k), 1'b1, 5'd5, 8'd0, 32'h0000_0001, 1'b0);
    end
  endtask

  task automatic t_lsl;
    for (int n = 1; n < 32; n++)
      apply("R5 lsl", 3'd0, 1'b0, 5'(n), 8'd0, 32'h9ABC_DEF1 ^ (32'h1 << n), 1'b0);
  endtask

  task automatic t_right;
    for (int n = 1; n < 32; n++) begin
      apply("R6 lsr", 3'd1, 1'b1, 5'd0, 8'(n), 32'hF0E1_D2C3 ^ (32'h1 << (n-1)), 1'b1);
      apply("R6 asr", 3'd2, 1'b0, 5'(n), 8'd0, 32'h8F0E_1D2C ^ (32'h1 << (n-1)), 1'b0);
      apply("R6 asr pos", 3'd2, 1'b1, 5'd0, 8'(n), 32'h7F0E_1D2D, 1'b0);
    end
  endtask

  task automatic t_logic_wide;
    apply("R7 lsl 32", 3'd0, 1'b1, 5'd0, 8'd32, 32'h0000_0001, 1'b0);
    apply("R7 lsl 32", 3'd0, 1'b1, 5'd0, 8'd32, 32'hFFFF_FFFE, 1'b1);
    apply("R7 lsr 32", 3'd1, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
    apply("R7 lsl 33", 3'd0, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1);
    apply("R7 lsr 33", 3'd1, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1);
    apply("R7 lsr 255", 3'd1, 1'b1, 5'd0, 8'd255, 32'hFFFF_FFFF, 1'b1);
    apply("R7 lsl 64", 3'd0, 1'b1, 5'd0, 8'd64, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_asr_wide;
    apply("R8 asr 32 neg", 3'd2, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
    apply("R8 asr 40 pos", 3'd2, 1'b1, 5'd0, 8'd40, 32'h7FFF_FFFF, 1'b1);
    apply("R8 asr 255", 3'd2, 1'b1, 5'd0, 8'd255, 32'hC000_0000, 1'b0);
  endtask

  task automatic t_ror;
    for (int n = 1; n < 32; n++)
      apply("R9 ror", 3'd3, 1'b0, 5'(n), 8'd0, 32'h1357_9BDF, 1'b0);
    apply("R9 ror 32", 3'd3, 1'b1, 5'd0, 8'd32, 32'h8000_0001, 1'b0);
    apply("R9 ror 64", 3'd3, 1'b1, 5'd0, 8'd64, 32'h7FFF_FFFE, 1'b1);
    apply("R9 ror 37", 3'd3, 1'b1, 5'd0, 8'd37, 32'h0000_0010, 1'b0);
    apply("R9 ror 224", 3'd3, 1'b1, 5'd0, 8'd224, 32'hCAFE_F00D, 1'b0);
  endtask

  task automatic t_rrx;
    apply("R10 rrx c1", 3'd4, 1'b1, 5'd7, 8'd99, 32'h0000_0002, 1'b1);
    apply("R10 rrx c0", 3'd4, 1'b0, 5'd0, 8'd0, 32'hFFFF_FFFF, 1'b0);
    apply("R10 rrx zero", 3'd4, 1'b1, 5'd0, 8'd0, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_flags;
    apply("R11 neg", 3'd0, 1'b0, 5'd31, 8'd0, 32'h0000_0001, 1'b0);
    apply("R11 zero", 3'd1, 1'b0, 5'd4, 8'd0, 32'h0000_000F, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] seed = 32'h2468_ACE1;
    for (int i = 0; i < 400; i++) begin
      seed = {seed[30:0], seed[31] ^ seed[21] ^ seed[1] ^ seed[0]};
      apply("R2 sweep", 3'(seed[2:0] % 3'd5), seed[3], seed[8:4], seed[16:9],
            seed ^ 32'h5A5A_3C3C, seed[17]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_bad_codes();
    t_amount_source();
    t_imm_zero();
    t_zero_amt();
    t_lsl();
    t_right();
    t_logic_wide();
    t_asr_wide();
    t_ror();
    t_rrx();
    t_flags();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule